// File: doc/BRIEF.md
# Read-Sequence Write-Protection Unlocker

This block sits on the write path of a byte-wide nonvolatile memory model. It watches the stream of read cycles for two fixed chains of seven read addresses. One chain lowers a protect flag and the other raises it. The flag is used elsewhere to gate program and erase commands. No key data is written. The two chains share their first six addresses and differ only in the seventh.

Each read reaches the block as a single-cycle strobe with its address already latched upstream. Each write reaches it as a single-cycle strobe. The block never sees data. Only the low 13 address bits take part in matching.

A tracker state machine has seven states. `TRK_IDLE` means no step has been matched. `TRK_GOT1` through `TRK_GOT6` mean that many leading steps have matched. The transitions are:
- ADVANCE: a read that hits the expected next address moves one state forward.
- RESTART: a read that misses goes to `TRK_GOT1` if its key is 1823h, and to `TRK_IDLE` otherwise.
- FINISH: any read in `TRK_GOT6` ends the attempt. The key 041Ah issues a clear request and the key 040Ah issues a set request. The tracker then leaves through the same rule as RESTART.
- ABORT: any write strobe returns the tracker to `TRK_IDLE`.

Top module: `rdseq_protect`

## Requirements
- R1: While reset is asserted and after it is released, `protect` is 1.
- R2: Seven reads whose low 13 address bits are 1823h, 1820h, 1822h, 0418h, 041Bh, 0419h, 041Ah clear `protect`. The flag changes on the clock edge that captures the seventh read and stays 1 through the first six.
- R3: Seven reads with the same first six keys and 040Ah as the seventh set `protect` on the edge that captures the seventh read.
- R4: Address bits above bit 12 are ignored. A chain that carries arbitrary upper bits behaves exactly like the same chain without them.
- R5: A read that misses the expected step discards the partial match. If that read's key is 1823h, it counts as step one of a new attempt.
- R6: A write strobe discards any partial match. A read strobe in the same cycle as a write strobe is ignored.
- R7: Cycles with no strobe between the reads of a chain neither break nor advance it.
- R8: `protect` changes only when a chain completes. An unlock chain leaves an already-clear flag at 0 and a lock chain leaves an already-set flag at 1. A seventh read that is neither final key leaves the flag unchanged, and idle cycles leave it unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rd_stb | input | 1 | Single-cycle pulse, one per read cycle |
| rd_addr | input | ADDR_W | Latched address of the read, valid with `rd_stb` |
| wr_stb | input | 1 | Single-cycle pulse, one per write cycle |
| protect | output | 1 | 1 = program and erase must be blocked |

## Verification
The assertions assume the following about the inputs:
- Reset is held low for at least one edge before any strobe arrives.
- `rd_addr` is only meaningful in cycles where `rd_stb` is high.
- Strobes arrive as already-formed single-cycle pulses.

The stimulus respects these assumptions. It holds reset for several cycles at start. It drives every strobe for exactly one clock, changing inputs on the falling edge. It sets the address together with its strobe. The one deliberate overlap of a read and a write strobe exercises the priority rule in R6.

// File: rtl/rdseq_pkg.sv
package rdseq_pkg;
    localparam int KEY_W      = 13;
    localparam int PREFIX_LEN = 6;
    localparam int IDX_W      = $clog2(PREFIX_LEN + 1);

    localparam logic [KEY_W-1:0] KEY_UNLOCK = 13'h041A;
    localparam logic [KEY_W-1:0] KEY_LOCK   = 13'h040A;

    typedef enum logic [IDX_W-1:0] {
        TRK_IDLE = 3'd0,
        TRK_GOT1 = 3'd1,
        TRK_GOT2 = 3'd2,
        TRK_GOT3 = 3'd3,
        TRK_GOT4 = 3'd4,
        TRK_GOT5 = 3'd5,
        TRK_GOT6 = 3'd6
    } trk_state_t;

    // Key expected at a given step of the shared prefix.
    function automatic logic [KEY_W-1:0] prefix_key(input logic [IDX_W-1:0] idx);
        logic [KEY_W-1:0] k;
        case (idx)
            3'd0:    k = 13'h1823;
            3'd1:    k = 13'h1820;
            3'd2:    k = 13'h1822;
            3'd3:    k = 13'h0418;
            3'd4:    k = 13'h041B;
            3'd5:    k = 13'h0419;
            default: k = 13'h1FFF;
        endcase
        return k;
    endfunction
endpackage

// File: rtl/rdseq_key_match.sv
module rdseq_key_match
    import rdseq_pkg::*;
#(
    parameter int ADDR_W = 19
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [IDX_W-1:0]  step_idx,
    output logic              hit_next,
    output logic              hit_first,
    output logic              hit_unlock,
    output logic              hit_lock
);
    logic [KEY_W-1:0] key;

    generate
        if (ADDR_W > KEY_W) begin : g_wide
            logic unused_hi;
            assign unused_hi = ^addr[ADDR_W-1:KEY_W];
            assign key = addr[KEY_W-1:0];
        end else begin : g_narrow
            assign key = KEY_W'(addr);
        end
    endgenerate

    always_comb begin
        hit_next   = (step_idx < IDX_W'(PREFIX_LEN)) && (key == prefix_key(step_idx));
        hit_first  = (key == prefix_key('0));
        hit_unlock = (key == KEY_UNLOCK);
        hit_lock   = (key == KEY_LOCK);
    end
endmodule

// File: rtl/rdseq_tracker.sv
module rdseq_tracker
    import rdseq_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rd_stb,
    input  logic             wr_stb,
    input  logic             hit_next,
    input  logic             hit_first,
    input  logic             hit_unlock,
    input  logic             hit_lock,
    output logic [IDX_W-1:0] step_idx,
    output logic             unlock_req,
    output logic             lock_req
);
    trk_state_t state_q, state_d;
    logic       rd_ok;

    assign rd_ok = rd_stb && !wr_stb;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= TRK_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        if (wr_stb) begin
            state_d = TRK_IDLE;                                   // ABORT
        end else if (rd_stb) begin
            unique case (state_q)
                TRK_GOT6: state_d = hit_first ? TRK_GOT1 : TRK_IDLE;  // FINISH
                TRK_IDLE, TRK_GOT1, TRK_GOT2, TRK_GOT3,
                TRK_GOT4, TRK_GOT5: begin
                    if (hit_next)       state_d = trk_state_t'(state_q + 1'b1); // ADVANCE
                    else if (hit_first) state_d = TRK_GOT1;               // RESTART
                    else                state_d = TRK_IDLE;               // RESTART
                end
                default: state_d = TRK_IDLE;
            endcase
        end
    end

    always_comb begin
        step_idx   = IDX_W'(state_q);
        unlock_req = 1'b0;
        lock_req   = 1'b0;
        unique case (state_q)
            TRK_GOT6: begin
                unlock_req = rd_ok && hit_unlock;
                lock_req   = rd_ok && hit_lock;
            end
            default: ;
        endcase
    end

    // R6: a write leaves no partial match behind
    p_wr_abort_r6: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb |=> state_q == TRK_IDLE);

    // R5: the tracker moves forward by at most one step per read
    p_advance_one_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q > TRK_GOT1 && state_q != $past(state_q))
            |-> ($past(state_q) == trk_state_t'(state_q - 1'b1)));

    // R2 / R3: never both outcomes at once
    p_req_excl_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({unlock_req, lock_req}));
endmodule

// File: rtl/rdseq_prot_flag.sv
module rdseq_prot_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set_req,
    input  logic clr_req,
    output logic protect_q
);
    always_ff @(posedge clk) begin
        if (!rst_n)       protect_q <= 1'b1;
        else if (set_req) protect_q <= 1'b1;
        else if (clr_req) protect_q <= 1'b0;
    end

    // R1: reset leaves the flag set
    p_reset_set_r1: assert property (@(posedge clk)
        !rst_n |=> protect_q);

    // R8: without a request the flag holds
    p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!set_req && !clr_req) |=> $stable(protect_q));
endmodule

// File: rtl/rdseq_protect.sv
module rdseq_protect
    import rdseq_pkg::*;
#(
    parameter int ADDR_W = 19
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_stb,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic              wr_stb,
    output logic              protect
);
    logic [IDX_W-1:0] step_idx;
    logic hit_next, hit_first, hit_unlock, hit_lock;
    logic unlock_req, lock_req;

    rdseq_key_match #(.ADDR_W(ADDR_W)) u_match (
        .addr(rd_addr), .step_idx(step_idx),
        .hit_next(hit_next), .hit_first(hit_first),
        .hit_unlock(hit_unlock), .hit_lock(hit_lock)
    );

    rdseq_tracker u_trk (
        .clk(clk), .rst_n(rst_n), .rd_stb(rd_stb), .wr_stb(wr_stb),
        .hit_next(hit_next), .hit_first(hit_first),
        .hit_unlock(hit_unlock), .hit_lock(hit_lock),
        .step_idx(step_idx), .unlock_req(unlock_req), .lock_req(lock_req)
    );

    rdseq_prot_flag u_flag (
        .clk(clk), .rst_n(rst_n), .set_req(lock_req), .clr_req(unlock_req),
        .protect_q(protect)
    );

    // R2: the flag only drops after a read that no write overrode
    p_fall_on_read_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(protect) |-> ($past(rd_stb) && !$past(wr_stb)));

    // R3: the flag only rises after such a read, once out of reset
    p_rise_on_read_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(protect) && $past(rst_n)) |-> ($past(rd_stb) && !$past(wr_stb)));
endmodule

// File: tb/sim_rdseq_protect.sv
module sim_rdseq_protect;
    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W     = 19;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic rd_stb = 1'b0;
    logic wr_stb = 1'b0;
    logic [ADDR_W-1:0] rd_addr = '0;
    logic protect;
    int errors = 0;
    int checks = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    rdseq_protect #(.ADDR_W(ADDR_W)) u0 (
        .clk(clk), .rst_n(rst_n), .rd_stb(rd_stb), .rd_addr(rd_addr),
        .wr_stb(wr_stb), .protect(protect)
    );

    task automatic chk(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: protect=%b expected %b", req, act, exp);
        end
    endtask

    task automatic rd(input logic [ADDR_W-1:0] a);
        @(negedge clk); rd_stb = 1'b1; rd_addr = a;
        @(negedge clk); rd_stb = 1'b0; rd_addr = '0;
    endtask

    task automatic wr();
        @(negedge clk); wr_stb = 1'b1;
        @(negedge clk); wr_stb = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic prefix(input logic [ADDR_W-1:0] hi);
        rd(hi | 19'h1823); rd(hi | 19'h1820); rd(hi | 19'h1822);
        rd(hi | 19'h0418); rd(hi | 19'h041B); rd(hi | 19'h0419);
    endtask

    task automatic t_reset();
        chk("R1 during reset", protect, 1'b1);
        @(negedge clk); rst_n = 1'b1;
        idle(2);
        chk("R1 after reset", protect, 1'b1);
    endtask

    task automatic t_unlock();
        prefix('0);
        chk("R2 still set after six steps", protect, 1'b1);
        rd(19'h041A);
        chk("R2 unlock chain", protect, 1'b0);
    endtask

    task automatic t_lock();
        prefix('0); rd(19'h040A);
        chk("R3 lock chain", protect, 1'b1);
    endtask

    task automatic t_upper_bits();
        prefix(19'h7A000); rd(19'h5E41A);
        chk("R4 unlock with upper bits", protect, 1'b0);
        prefix(19'h2E000); rd(19'h6440A);
        chk("R4 lock with upper bits", protect, 1'b1);
    endtask

    task automatic t_restart();
        rd(19'h1823); rd(19'h1820); rd(19'h1822); rd(19'h0000);
        rd(19'h0418); rd(19'h041B); rd(19'h0419); rd(19'h041A);
        chk("R5 mismatch discards match", protect, 1'b1);
        rd(19'h1823); rd(19'h1820); rd(19'h1823);
        rd(19'h1820); rd(19'h1822); rd(19'h0418); rd(19'h041B); rd(19'h0419); rd(19'h041A);
        chk("R5 1823h restarts as step one", protect, 1'b0);
        prefix('0); rd(19'h040A);
        chk("R5 relock", protect, 1'b1);
    endtask

    task automatic t_write_abort();
        rd(19'h1823); rd(19'h1820); rd(19'h1822); wr();
        rd(19'h0418); rd(19'h041B); rd(19'h0419); rd(19'h041A);
        chk("R6 write aborts chain", protect, 1'b1);
        prefix('0);
        @(negedge clk); rd_stb = 1'b1; wr_stb = 1'b1; rd_addr = 19'h041A;
        @(negedge clk); rd_stb = 1'b0; wr_stb = 1'b0; rd_addr = '0;
        chk("R6 read with write ignored", protect, 1'b1);
        rd(19'h041A);
        chk("R6 chain gone after overlap", protect, 1'b1);
    endtask

    task automatic t_gaps();
        rd(19'h1823); idle(3); rd(19'h1820); idle(1); rd(19'h1822);
        rd(19'h0418); idle(5); rd(19'h041B); rd(19'h0419); idle(2); rd(19'h041A);
        chk("R7 idle gaps tolerated", protect, 1'b0);
    endtask

    task automatic t_hold();
        prefix('0); rd(19'h041A);
        chk("R8 unlock while clear", protect, 1'b0);
        prefix('0); rd(19'h0400);
        chk("R8 bad seventh step", protect, 1'b0);
        idle(20);
        chk("R8 idle hold clear", protect, 1'b0);
        prefix('0); rd(19'h040A);
        prefix('0); rd(19'h040A);
        chk("R8 lock while set", protect, 1'b1);
        wr(); idle(10);
        chk("R8 hold set", protect, 1'b1);
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        errors++; checks++;
        $display("FAIL watchdog: run hung");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        idle(3);
        t_reset();
        t_unlock();
        t_lock();
        t_upper_bits();
        t_restart();
        t_write_abort();
        t_gaps();
        t_hold();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule